// File: doc/BRIEF.md
# Fault Exception Entry Sequencer

This block carries out the hardware side of entering a fault handler. When a fault request arrives together with an error code, it takes a snapshot of the interrupted context: code selector, stack selector, stack pointer, instruction pointer and flags. It then writes an exception frame into stack memory, one 32-bit word per clock cycle. When the frame is complete, it presents the handler's code selector and instruction pointer along with the new stack selector and pointer. A single-cycle done pulse marks the moment these values become valid.

The privilege level of the interrupted code comes from the low two bits of its code selector. For a fault taken at privilege 0, the frame is built on the current stack. For a fault taken at any other privilege level, the block first switches to a kernel stack given by a selector/pointer pair. The surrounding logic supplies that pair from the current task state. The block then saves the old stack selector and pointer ahead of the usual words. The handler address comes from configuration inputs, and the handler always runs at privilege 0.

Top module: `fault_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `wr_en` and `done` are 0, and `new_ss`, `new_esp`, `new_cs` and `new_eip` are all zero.
- R2: The interrupted privilege level is `cur_cs[1:0]`. The value 0 selects the inner (same-stack) frame. Any nonzero value selects the outer (stack-switch) frame.
- R3: An inner frame starts from base `cur_esp` and writes exactly four words, in this order: `cur_eflags`, `cur_cs`, `cur_eip`, `err_code`.
- R4: An outer frame starts from base `kstack_esp` and writes exactly six words, in this order: `cur_ss`, `cur_esp`, `cur_eflags`, `cur_cs`, `cur_eip`, `err_code`.
- R5: Each write goes to the stack pointer minus 4, which then becomes the new stack pointer. The first write goes to base−4. Addresses wrap modulo 2^32.
- R6: A 16-bit selector is written as a 32-bit word with bits 31:16 set to zero.
- R7: Writes take place on consecutive cycles with no gaps. The first write occurs in the cycle after the edge that accepts the fault.
- R8: `done` is high for exactly one cycle, in the cycle right after the last write. In that cycle `new_esp` equals the address of the last write. `new_ss` is `cur_ss` for an inner frame and `kstack_ss` for an outer frame.
- R9: With `done`, `new_cs` is `hdl_cs` with bits 1:0 cleared and `new_eip` is `hdl_eip`. All four `new_*` outputs hold their values until the next `done`.
- R10: `busy` is high from the cycle after acceptance up to and including the `done` cycle. A `fault_req` sampled while `busy` is high is ignored.
- R11: All context, error code, kernel stack and handler inputs are captured at the accepting edge. Later changes to them have no effect on the frame in progress or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 1 | Fault request, accepted when idle |
| err_code | input | 32 | Error code for the frame |
| cur_cs | input | 16 | Interrupted code selector |
| cur_ss | input | 16 | Interrupted stack selector |
| cur_esp | input | 32 | Interrupted stack pointer |
| cur_eip | input | 32 | Faulting instruction pointer |
| cur_eflags | input | 32 | Interrupted flags |
| kstack_ss | input | 16 | Kernel stack selector from task state |
| kstack_esp | input | 32 | Kernel stack pointer from task state |
| hdl_cs | input | 16 | Handler code selector |
| hdl_eip | input | 32 | Handler entry address |
| wr_en | output | 1 | Stack memory write strobe |
| wr_addr | output | 32 | Stack memory byte address |
| wr_data | output | 32 | Stack memory write word |
| busy | output | 1 | Frame being built |
| done | output | 1 | One-cycle entry-complete pulse |
| new_ss | output | 16 | Stack selector after entry |
| new_esp | output | 32 | Stack pointer after entry |
| new_cs | output | 16 | Code selector after entry |
| new_eip | output | 32 | Instruction pointer after entry |

## Verification
The bench targets several failure modes:
- Privilege levels 1, 2 and 3 must all take the stack switch. A design that tests only for level 3 would write four words on the wrong stack.
- A stack base near zero checks that addresses wrap. A selector of 0xFFFF checks zero extension. A design that sign-extends would write ones into the upper half.
- Context inputs are scrambled every cycle while a frame is in progress, and fault requests are held high across whole frames. A design that reads live inputs, or that restarts on a second request, would then produce wrong words or extra frames.
- A handler selector with nonzero low bits checks that entry forces privilege 0.

// File: rtl/fault_entry_seq.sv
module fault_entry_seq #(
  parameter int DW = 32,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_req,
  input  logic [DW-1:0]   err_code,
  input  logic [SELW-1:0] cur_cs,
  input  logic [SELW-1:0] cur_ss,
  input  logic [DW-1:0]   cur_esp,
  input  logic [DW-1:0]   cur_eip,
  input  logic [DW-1:0]   cur_eflags,
  input  logic [SELW-1:0] kstack_ss,
  input  logic [DW-1:0]   kstack_esp,
  input  logic [SELW-1:0] hdl_cs,
  input  logic [DW-1:0]   hdl_eip,
  output logic            wr_en,
  output logic [DW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            busy,
  output logic            done,
  output logic [SELW-1:0] new_ss,
  output logic [DW-1:0]   new_esp,
  output logic [SELW-1:0] new_cs,
  output logic [DW-1:0]   new_eip
);
  localparam int WB = DW / 8;
  localparam int NOUT = 6;
  localparam int NIN = 4;
  localparam int IW = $clog2(NOUT);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_DONE} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic            outer;
  logic [DW-1:0]   sp;
  logic [SELW-1:0] s_cs, s_ss, s_kss, s_hcs;
  logic [DW-1:0]   s_esp, s_eip, s_efl, s_err, s_heip;
  logic [IW-1:0]   last_idx;
  logic [IW-1:0]   slot;
  logic            accept;

  assign accept   = (st == S_IDLE) && fault_req;
  assign last_idx = outer ? IW'(NOUT - 1) : IW'(NIN - 1);
  assign slot     = outer ? idx : idx + IW'(NOUT - NIN);
  assign wr_en    = (st == S_PUSH);
  assign wr_addr  = sp - DW'(WB);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  always_comb begin
    case (slot)
      IW'(0):  wr_data = DW'(s_ss);
      IW'(1):  wr_data = s_esp;
      IW'(2):  wr_data = s_efl;
      IW'(3):  wr_data = DW'(s_cs);
      IW'(4):  wr_data = s_eip;
      default: wr_data = s_err;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      outer  <= 1'b0;
      sp     <= '0;
      s_cs   <= '0;
      s_ss   <= '0;
      s_kss  <= '0;
      s_hcs  <= '0;
      s_esp  <= '0;
      s_eip  <= '0;
      s_efl  <= '0;
      s_err  <= '0;
      s_heip <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st     <= S_PUSH;
          idx    <= '0;
          outer  <= (cur_cs[1:0] != 2'b00);
          sp     <= (cur_cs[1:0] != 2'b00) ? kstack_esp : cur_esp;
          s_cs   <= cur_cs;
          s_ss   <= cur_ss;
          s_kss  <= kstack_ss;
          s_hcs  <= hdl_cs;
          s_esp  <= cur_esp;
          s_eip  <= cur_eip;
          s_efl  <= cur_eflags;
          s_err  <= err_code;
          s_heip <= hdl_eip;
        end
        S_PUSH: begin
          sp  <= wr_addr;
          idx <= idx + IW'(1);
          if (idx == last_idx) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_ss  <= '0;
      new_esp <= '0;
      new_cs  <= '0;
      new_eip <= '0;
    end else if (st == S_PUSH && idx == last_idx) begin
      new_ss  <= outer ? s_kss : s_ss;
      new_esp <= wr_addr;
      new_cs  <= {s_hcs[SELW-1:2], 2'b00};
      new_eip <= s_heip;
    end
  end

  p_write_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) - DW'(WB));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && new_esp == $past(wr_addr)));

  p_kernel_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_cs[1:0] == 2'b00);

  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(done) && $past(rst_n)) |-> ($stable(new_esp) && $stable(new_cs)));

  p_first_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(busy) && $past(fault_req)) |-> wr_en);
endmodule

// File: tb/tb_fault_entry_seq.sv
module tb_fault_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_req = 1'b0;
  logic [31:0] err_code = '0, cur_esp = '0, cur_eip = '0, cur_eflags = '0;
  logic [31:0] kstack_esp = '0, hdl_eip = '0;
  logic [15:0] cur_cs = '0, cur_ss = '0, kstack_ss = '0, hdl_cs = '0;
  logic        wr_en, busy, done;
  logic [31:0] wr_addr, wr_data, new_esp, new_eip;
  logic [15:0] new_ss, new_cs;

  always #2 clk = ~clk;

  fault_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .err_code(err_code),
    .cur_cs(cur_cs), .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eip(cur_eip),
    .cur_eflags(cur_eflags), .kstack_ss(kstack_ss), .kstack_esp(kstack_esp),
    .hdl_cs(hdl_cs), .hdl_eip(hdl_eip), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .new_ss(new_ss),
    .new_esp(new_esp), .new_cs(new_cs), .new_eip(new_eip)
  );

  int compared = 0;
  int mismatched = 0;
  int frames = 0;

  int          m_state = 0;
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [15:0] e_ss = '0, e_cs = '0;
  logic [31:0] e_esp = '0, e_eip = '0;
  logic        m_outer = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      q_addr.delete();
      q_data.delete();
      e_ss = '0; e_cs = '0; e_esp = '0; e_eip = '0;
    end else if (m_state == 0 && fault_req) begin
      logic [31:0] words[$];
      logic [31:0] p;
      m_outer = (cur_cs % 4) != 0;
      p = m_outer ? kstack_esp : cur_esp;
      words.delete();
      if (m_outer) begin
        words.push_back({16'h0, cur_ss});
        words.push_back(cur_esp);
      end
      words.push_back(cur_eflags);
      words.push_back({16'h0, cur_cs});
      words.push_back(cur_eip);
      words.push_back(err_code);
      foreach (words[i]) begin
        p = p - 32'd4;
        q_addr.push_back(p);
        q_data.push_back(words[i]);
      end
      e_ss  = m_outer ? kstack_ss : cur_ss;
      e_esp = p;
      e_cs  = hdl_cs & 16'hFFFC;
      e_eip = hdl_eip;
      m_state = 1;
      frames++;
    end else if (m_state == 1) begin
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
      if (q_addr.size() == 0) m_state = 2;
    end else if (m_state == 2) begin
      m_state = 0;
    end
  end

  always @(negedge clk) begin
    if (m_state == 1) begin
      chk("R7", "wr_en", 32'(wr_en), 32'd1);
      chk(m_outer ? "R4/R5" : "R3/R5", "wr_addr", wr_addr, q_addr[0]);
      chk(m_outer ? "R4/R6/R11" : "R3/R6/R11", "wr_data", wr_data, q_data[0]);
      chk("R10", "busy", 32'(busy), 32'd1);
      chk("R8", "done early", 32'(done), 32'd0);
    end else if (m_state == 2) begin
      chk("R8", "done", 32'(done), 32'd1);
      chk("R8", "extra write", 32'(wr_en), 32'd0);
      chk("R10", "busy at done", 32'(busy), 32'd1);
    end else begin
      chk(rst_n ? "R10" : "R1", "idle busy", 32'(busy), 32'd0);
      chk(rst_n ? "R10" : "R1", "idle write", 32'(wr_en), 32'd0);
      chk(rst_n ? "R8" : "R1", "idle done", 32'(done), 32'd0);
    end
    if (m_state != 1) begin
      chk(rst_n ? "R8" : "R1", "new_ss", 32'(new_ss), 32'(e_ss));
      chk(rst_n ? "R8" : "R1", "new_esp", new_esp, e_esp);
      chk(rst_n ? "R9" : "R1", "new_cs", 32'(new_cs), 32'(e_cs));
      chk(rst_n ? "R9" : "R1", "new_eip", new_eip, e_eip);
    end
  end

  task automatic scramble();
    err_code = $urandom; cur_esp = $urandom; cur_eip = $urandom; cur_eflags = $urandom;
    kstack_esp = $urandom; hdl_eip = $urandom; cur_cs = 16'($urandom);
    cur_ss = 16'($urandom); kstack_ss = 16'($urandom); hdl_cs = 16'($urandom);
  endtask

  task automatic fire(input logic [15:0] cs, input logic [31:0] esp, input logic [31:0] kesp,
                      input logic [15:0] hcs);
    @(negedge clk);
    scramble();
    cur_cs = cs; cur_esp = esp; kstack_esp = kesp; hdl_cs = hcs;
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    while (m_state != 0) begin
      scramble();
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R3: privilege 0, inner frame
    fire(16'h0010, 32'h0000_8000, 32'h1234_5678, 16'h0008);
    // R2 R4: privilege 3, stack switch
    fire(16'h001B, 32'h7FFF_F000, 32'hC000_2000, 16'h000B);
    // R2: privilege 1 and 2 also switch
    fire(16'h0021, 32'h0000_4000, 32'hC000_3000, 16'h0010);
    fire(16'h0032, 32'h0000_5000, 32'hC000_4000, 16'h0013);
    // R5: wrap below zero; R6: selector all ones
    fire(16'hFFFC, 32'h0000_0008, 32'h0, 16'hFFFF);
    fire(16'hFFFF, 32'h0000_1000, 32'h0000_000C, 16'h0002);
    // R10: request held high across frames is taken once per idle
    @(negedge clk);
    cur_cs = 16'h0003; kstack_esp = 32'hC000_8000;
    fault_req = 1'b1;
    repeat (20) begin
      @(negedge clk);
      scramble();
    end
    fault_req = 1'b0;
    while (m_state != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      fire(16'($urandom), $urandom, $urandom, 16'($urandom));
      repeat (k % 3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    if (frames < 18) begin
      compared++; mismatched++;
      $display("FAIL R10 frame count: actual %0d expected >= 18", frames);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule